// File: doc/BRIEF.md
# DMA Channel Register Block

This block is the register front end of a single DMA channel on a 32-bit memory-mapped bus. Software programs a set of pointer registers and a size register, then steers the channel through one control word. Writes to that word are commands rather than stores. Separate bits turn on the enable, update and device-to-memory flags, another bit clears the completion flag, and a reset command clears all four flags at once. Reading the same word returns the stored flags in its upper byte.

The transfer engine sits beside the block. It sees the enable, update and direction flags, together with the current next and limit pointers. When it finishes, it returns a one-cycle completion pulse. The pulse sets the completion flag, which doubles as the interrupt output, and drops the enable.

Every bus access gets a registered response exactly one cycle later. Only full 32-bit accesses are legal. A narrower access is rejected with an error flag, returns zero data and changes nothing. Offsets that map to no register read as zero and ignore writes, without an error.

Top module: `dmac_chan_regs`

## Requirements
- R1: After reset the enable, update, completion and direction flags are 0, every pointer and size register is 0, and the interrupt output is low.
- R2: A 32-bit write to the control word (offset 0x0) with bit 1 set sets the enable flag. A 0 in bit 1 leaves the flag unchanged.
- R3: In a control write, bit 2 set sets the update flag and bit 4 set sets the device-to-memory flag. A 0 in either bit leaves its flag unchanged.
- R4: In a control write, bit 3 set clears the completion flag, and the interrupt output falls with it.
- R5: In a control write, bit 0 set clears enable, update, completion and direction together.
- R6: When one control write carries bit 0 together with set bits, the reset is applied first and the set bits after it.
- R7: A read of the control word returns enable in bit 24, update in bit 25, completion in bit 26 and direction in bit 27, with every other bit 0.
- R8: The next, limit, start and stop pointers sit at offsets 0x4000, 0x4004, 0x4008 and 0x400C, the initial-buffer pointer at 0x4200 and the size register at 0x4204. Each reads back the last 32-bit value written to it. The next and limit values are also driven to the engine.
- R9: The access size code is 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. Any access whose code is not 2 gets an error response with zero data and changes no register.
- R10: A 32-bit access to any offset outside the map reads as zero without an error, and a write there changes no register.
- R11: A completion pulse sets the completion flag and clears enable. The interrupt output equals the completion flag. If a pulse arrives in the same cycle as a clear-complete command, the pulse wins.
- R12: Every access selected in one cycle gets exactly one response in the next cycle, and no response appears in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| bus_addr | input | ADDR_W | Channel-relative byte offset |
| bus_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after bus_sel |
| rsp_err | output | 1 | Access rejected because it was not 32 bits wide |
| rsp_rdata | output | DATA_W | Read data; zero for writes and rejected accesses |
| done_pulse | input | 1 | Completion pulse from the transfer engine |
| xfer_en | output | 1 | Channel enable flag |
| xfer_dev2mem | output | 1 | Direction flag, 1 = device to memory |
| xfer_update | output | 1 | Update flag |
| xfer_next | output | DATA_W | Current next pointer |
| xfer_limit | output | DATA_W | Current limit pointer |
| complete_irq | output | 1 | Completion interrupt, equal to the completion flag |

## Verification
The bench aims at the command semantics of the control word. If the design stored the written value, a zero write would drop flags that had been set. If it applied the sets before the reset, a combined reset-and-set write would come back empty. If it let clear-complete beat a completion pulse in the same cycle, a finished transfer would never raise its interrupt. Byte and halfword accesses carrying a reset command, and writes to unmapped offsets, are also aimed at the control word and the pointers. A design that decoded them would lose programmed flags or corrupt a pointer, and the readback that follows exposes it. Back-to-back accesses confirm that each access gets exactly one response, with none dropped and none duplicated.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int unsigned NUM_PTR = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam logic [15:0] OFF_CTRL = 16'h0000;
  localparam logic [15:0] OFF_PTR_LO = 16'h4000;
  localparam logic [15:0] OFF_PTR_HI = 16'h4200;

  // command bit positions in a control write
  localparam int unsigned CMD_RST    = 0;
  localparam int unsigned CMD_SETEN  = 1;
  localparam int unsigned CMD_SETUPD = 2;
  localparam int unsigned CMD_CLRCMP = 3;
  localparam int unsigned CMD_DIR    = 4;
  localparam int unsigned CMD_W      = 5;

  // status bit positions in a control read
  localparam int unsigned ST_EN  = 24;
  localparam int unsigned ST_UPD = 25;
  localparam int unsigned ST_CMP = 26;
  localparam int unsigned ST_DIR = 27;

  typedef struct packed {
    logic dir;
    logic cmp;
    logic upd;
    logic en;
  } chan_flags_t;

  // index 0..3: next, limit, start, stop; 4: initial buffer; 5: size
  function automatic logic [15:0] ptr_offset(input int unsigned idx);
    if (idx < 4) return OFF_PTR_LO + 16'(4 * idx);
    else         return OFF_PTR_HI + 16'(4 * (idx - 4));
  endfunction

endpackage

// File: rtl/dmac_rst_sync.sv
module dmac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/dmac_decode.sv
module dmac_decode
  import dmac_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned N_PTR  = NUM_PTR
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              bad_size,
  output logic              rd_ctrl,
  output logic              wr_ctrl,
  output logic [N_PTR-1:0]  rd_ptr,
  output logic [N_PTR-1:0]  wr_ptr
);
  logic word_ok;
  logic ctrl_hit;

  always_comb begin
    word_ok  = bus_sel && (bus_size == SZ_WORD);
    bad_size = bus_sel && (bus_size != SZ_WORD);
    ctrl_hit = word_ok && (bus_addr == ADDR_W'(OFF_CTRL));
    rd_ctrl  = ctrl_hit && !bus_we;
    wr_ctrl  = ctrl_hit && bus_we;
  end

  for (genvar i = 0; i < N_PTR; i++) begin : g_hit
    logic hit;
    assign hit       = word_ok && (bus_addr == ADDR_W'(ptr_offset(i)));
    assign rd_ptr[i] = hit && !bus_we;
    assign wr_ptr[i] = hit && bus_we;
  end
endmodule

// File: rtl/dmac_flags.sv
module dmac_flags
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              done_pulse,
  output chan_flags_t       flags_q
);
  chan_flags_t flags_d;
  logic        flags_ce;

  always_comb begin
    flags_ce = wr_ctrl || done_pulse;
    flags_d  = flags_q;
    if (wr_ctrl) begin
      // reset first, then the set and clear commands on top of it
      if (cmd[CMD_RST])    flags_d = '0;
      if (cmd[CMD_SETEN])  flags_d.en  = 1'b1;
      if (cmd[CMD_SETUPD]) flags_d.upd = 1'b1;
      if (cmd[CMD_CLRCMP]) flags_d.cmp = 1'b0;
      if (cmd[CMD_DIR])    flags_d.dir = 1'b1;
    end
    // the engine's completion event is applied last so it is never lost
    if (done_pulse) begin
      flags_d.cmp = 1'b1;
      flags_d.en  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_ce) flags_q <= flags_d;
  end
endmodule

// File: rtl/dmac_ptr_bank.sv
module dmac_ptr_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_PTR  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PTR-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ptr_q [N_PTR]
);
  for (genvar i = 0; i < N_PTR; i++) begin : g_reg
    logic [DATA_W-1:0] val_q;
    logic [DATA_W-1:0] val_d;

    always_comb val_d = wdata;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         val_q <= '0;
      else if (wr_ptr[i]) val_q <= val_d;
    end

    assign ptr_q[i] = val_q;
  end
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              done_pulse,
  output logic              xfer_en,
  output logic              xfer_dev2mem,
  output logic              xfer_update,
  output logic [DATA_W-1:0] xfer_next,
  output logic [DATA_W-1:0] xfer_limit,
  output logic              complete_irq
);
  localparam int unsigned IDX_NEXT  = 0;
  localparam int unsigned IDX_LIMIT = 1;

  logic              rst_sync_n;
  logic              bad_size;
  logic              rd_ctrl;
  logic              wr_ctrl;
  logic [NUM_PTR-1:0] rd_ptr;
  logic [NUM_PTR-1:0] wr_ptr;
  chan_flags_t       flags_q;
  logic [DATA_W-1:0] ptr_q [NUM_PTR];
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] rdata_d;
  logic              valid_d;
  logic              err_d;
  logic              valid_q;
  logic              err_q;
  logic [DATA_W-1:0] rdata_q;

  dmac_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  dmac_decode #(.ADDR_W(ADDR_W), .N_PTR(NUM_PTR)) i_decode (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_size (bus_size),
    .bus_addr (bus_addr),
    .bad_size (bad_size),
    .rd_ctrl  (rd_ctrl),
    .wr_ctrl  (wr_ctrl),
    .rd_ptr   (rd_ptr),
    .wr_ptr   (wr_ptr)
  );

  dmac_flags i_flags (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_ctrl    (wr_ctrl),
    .cmd        (bus_wdata[CMD_W-1:0]),
    .done_pulse (done_pulse),
    .flags_q    (flags_q)
  );

  dmac_ptr_bank #(.DATA_W(DATA_W), .N_PTR(NUM_PTR)) i_ptrs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_ptr (wr_ptr),
    .wdata  (bus_wdata),
    .ptr_q  (ptr_q)
  );

  always_comb begin
    stat_word         = '0;
    stat_word[ST_EN]  = flags_q.en;
    stat_word[ST_UPD] = flags_q.upd;
    stat_word[ST_CMP] = flags_q.cmp;
    stat_word[ST_DIR] = flags_q.dir;
  end

  // read mux: unmapped and narrow accesses select nothing and return zero
  always_comb begin
    rdata_d = rd_ctrl ? stat_word : '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (rd_ptr[i]) rdata_d = rdata_d | ptr_q[i];
    end
    valid_d = bus_sel;
    err_d   = bad_size;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_valid    = valid_q;
  assign rsp_err      = err_q;
  assign rsp_rdata    = rdata_q;
  assign xfer_en      = flags_q.en;
  assign xfer_dev2mem = flags_q.dir;
  assign xfer_update  = flags_q.upd;
  assign complete_irq = flags_q.cmp;
  assign xfer_next    = ptr_q[IDX_NEXT];
  assign xfer_limit   = ptr_q[IDX_LIMIT];
endmodule

// File: rtl/dmac_chan_regs_chk.sv
module dmac_chan_regs_chk
  import dmac_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              done_pulse,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              xfer_en,
  input logic              complete_irq
);
  logic ctl_word_wr;
  assign ctl_word_wr = bus_sel && bus_we && (bus_size == SZ_WORD) &&
                       (bus_addr == ADDR_W'(OFF_CTRL));

  // R12
  rsp_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> rsp_valid);

  // R12
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !rsp_valid);

  // R9
  narrow_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_size != SZ_WORD) |=> rsp_err);

  // R9
  err_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0));

  // R9
  narrow_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_size != SZ_WORD && !done_pulse) |=>
      ($stable(xfer_en) && $stable(complete_irq)));

  // R11
  done_sets_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> (complete_irq && !xfer_en));

  // R5
  rst_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_word_wr && bus_wdata[CMD_RST] && !bus_wdata[CMD_SETEN] && !done_pulse)
      |=> (!xfer_en && !complete_irq));

  // R2
  en_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_en) |-> $past(ctl_word_wr && bus_wdata[CMD_SETEN]));
endmodule

bind dmac_chan_regs dmac_chan_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .bus_sel      (bus_sel),
  .bus_we       (bus_we),
  .bus_size     (bus_size),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .done_pulse   (done_pulse),
  .rsp_valid    (rsp_valid),
  .rsp_err      (rsp_err),
  .rsp_rdata    (rsp_rdata),
  .xfer_en      (xfer_en),
  .complete_irq (complete_irq)
);

// File: tb/test_dmac_chan_regs.sv
module test_dmac_chan_regs;
  localparam logic [31:0] EN  = 32'h0100_0000;
  localparam logic [31:0] UPD = 32'h0200_0000;
  localparam logic [31:0] CMP = 32'h0400_0000;
  localparam logic [31:0] DIR = 32'h0800_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_size = 2'd2;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        done_pulse = 1'b0;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        xfer_en;
  logic        xfer_dev2mem;
  logic        xfer_update;
  logic [31:0] xfer_next;
  logic [31:0] xfer_limit;
  logic        complete_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  dmac_chan_regs i_dmac_chan_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_size     (bus_size),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata),
    .done_pulse   (done_pulse),
    .xfer_en      (xfer_en),
    .xfer_dev2mem (xfer_dev2mem),
    .xfer_update  (xfer_update),
    .xfer_next    (xfer_next),
    .xfer_limit   (xfer_limit),
    .complete_irq (complete_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input bit we, input bit [1:0] sz, input bit [15:0] a,
                        input bit [31:0] wd, input bit [31:0] ed, input bit ee,
                        input string tag, input bit dn = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_size = sz; bus_addr = a;
    bus_wdata = wd; done_pulse = dn;
    exp_q.push_back('{ed, ee, tag});
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; done_pulse = 1'b0;
  endtask

  task automatic wr(input bit [15:0] a, input bit [31:0] wd, input string tag);
    bus_op(1'b1, 2'd2, a, wd, 32'h0, 1'b0, tag);
  endtask

  task automatic rd(input bit [15:0] a, input bit [31:0] ed, input string tag);
    bus_op(1'b0, 2'd2, a, 32'h0, ed, 1'b0, tag);
  endtask

  task automatic pulse_done();
    @(negedge clk);
    bus_sel = 1'b0; done_pulse = 1'b1;
    @(negedge clk);
    done_pulse = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor: one response expected per queued access (R12)
  always @(negedge clk) begin
    if (rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12 actual unexpected response expected none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rsp_rdata !== e.data || rsp_err !== e.err) begin
          errors++;
          $display("FAIL %s actual data %h err %b expected data %h err %b",
                   e.tag, rsp_rdata, rsp_err, e.data, e.err);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    report();
  end

  initial begin
    logic [15:0] offs [6];
    logic [31:0] vals [6];
    offs = '{16'h4000, 16'h4004, 16'h4008, 16'h400C, 16'h4200, 16'h4204};
    for (int i = 0; i < 6; i++) vals[i] = 32'h1357_0000 + 32'(i * 32'h0101_0011);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", {31'h0, xfer_en}, 32'h0);
    chk("R1", {31'h0, complete_irq}, 32'h0);
    chk("R1", xfer_next, 32'h0);
    rd(16'h0000, 32'h0, "R1");
    rd(16'h4204, 32'h0, "R1");

    // R2 set-enable, zero leaves it
    wr(16'h0000, 32'h2, "R2");
    idle();
    chk("R2", {31'h0, xfer_en}, 32'h1);
    rd(16'h0000, EN, "R7");
    wr(16'h0000, 32'h0, "R2");
    rd(16'h0000, EN, "R2");

    // R3 update and direction
    wr(16'h0000, 32'h14, "R3");
    idle();
    chk("R3", {30'h0, xfer_update, xfer_dev2mem}, 32'h3);
    rd(16'h0000, EN | UPD | DIR, "R3");

    // R11 completion pulse
    pulse_done();
    chk("R11", {30'h0, complete_irq, xfer_en}, 32'h2);
    rd(16'h0000, UPD | CMP | DIR, "R11");

    // R4 clear-complete
    wr(16'h0000, 32'h8, "R4");
    idle();
    chk("R4", {31'h0, complete_irq}, 32'h0);
    rd(16'h0000, UPD | DIR, "R4");

    // R7 all flags, then R5 reset command
    wr(16'h0000, 32'h2, "R7");
    pulse_done();
    wr(16'h0000, 32'h2, "R7");
    rd(16'h0000, EN | UPD | CMP | DIR, "R7");
    wr(16'h0000, 32'h1, "R5");
    idle();
    chk("R5", {31'h0, complete_irq}, 32'h0);
    rd(16'h0000, 32'h0, "R5");

    // R6 reset plus sets in one write
    wr(16'h0000, 32'h4, "R6");
    wr(16'h0000, 32'h13, "R6");
    rd(16'h0000, EN | DIR, "R6");

    // R9 narrow accesses to the control word
    bus_op(1'b1, 2'd0, 16'h0000, 32'h1, 32'h0, 1'b1, "R9");
    bus_op(1'b0, 2'd1, 16'h0000, 32'h0, 32'h0, 1'b1, "R9");
    bus_op(1'b1, 2'd3, 16'h0000, 32'h1, 32'h0, 1'b1, "R9");
    rd(16'h0000, EN | DIR, "R9");

    // R8 pointer registers
    for (int i = 0; i < 6; i++) wr(offs[i], vals[i], "R8");
    for (int i = 0; i < 6; i++) rd(offs[i], vals[i], "R8");
    idle();
    chk("R8", xfer_next, vals[0]);
    chk("R8", xfer_limit, vals[1]);

    // R9 narrow write to a pointer is rejected
    bus_op(1'b1, 2'd0, 16'h4000, 32'hFFFF_FFFF, 32'h0, 1'b1, "R9");
    rd(16'h4000, vals[0], "R9");

    // R10 unmapped offsets
    wr(16'h4010, 32'hDEAD_BEEF, "R10");
    rd(16'h4010, 32'h0, "R10");
    wr(16'h0004, 32'h1, "R10");
    rd(16'h0004, 32'h0, "R10");
    rd(16'h0000, EN | DIR, "R10");
    for (int i = 0; i < 6; i++) rd(offs[i], vals[i], "R10");

    // R11 pulse beats clear-complete in the same cycle
    bus_op(1'b1, 2'd2, 16'h0000, 32'h8, 32'h0, 1'b0, "R11", 1'b1);
    idle();
    chk("R11", {30'h0, complete_irq, xfer_en}, 32'h2);
    rd(16'h0000, CMP | DIR, "R11");

    repeat (3) idle();
    chk("R12", 32'(exp_q.size()), 32'h0);
    report();
  end
endmodule